// File: doc/BRIEF.md
# Quad Special-Wakeup Request Register

This block is a register slave inside the manager of a four-core cluster. The hypervisor writes to it to raise or drop a special-wakeup request for any group of the cluster's cores, and reads it to learn whether the last request has completed. Core power sequencing is not modelled here, so completion is reported as soon as the request is written.

The register bus carries 64-bit data and accepts only whole, aligned 8-byte accesses. The register index is the byte address shifted right by three. Four bits of that index pick the cores a write applies to, as a one-hot-per-core mask. Those bits are ignored when the offset is decoded, so the request register appears at many aliased offsets. Each alias addresses a different subset of cores. Each core's request is driven out on its own wire, next to a shared done flag.

Top module: `quad_wakeup_regs`

## Requirements
- R1: After reset, all four core wakeup requests and the done flag are 0, and no read response is pending.
- R2: Bit numbers count from the least significant bit. A write to index 0x83C, with index bits 15..12 treated as a core mask and ignored when matching, sets the request of core i when index bit (15 - i) is 1 and data bit 63 is 1. Core i drives core_wake_req[i]. The output changes one cycle after the access.
- R3: A request-register write with data bit 63 equal to 0 clears the request of every selected core. Cores whose select bit is 0 keep their request.
- R4: Every accepted request-register write loads wake_done with data bit 63, whatever the core mask. This includes a write whose mask is all zero, which changes no core request.
- R5: A read of index 0x82C (with index bits 15..12 ignored) returns 64'h4800_0000_0000_0000 (bits 62 and 59) while wake_done is 1, and returns 0 otherwise.
- R6: A read of any other index returns all ones. This includes the request register and indexes with bits set above bit 15.
- R7: Writes to any index other than the request register change neither the core requests nor wake_done.
- R8: An access whose size is not 8 bytes, or whose byte address has a nonzero low three bits, is rejected. A rejected write has no effect, and a rejected read returns all ones.
- R9: rsp_valid is 1 for exactly the cycle after each read, and it stays 0 after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 35 | Byte address; index is acc_addr[34:3] |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 64 | Write data; bit 63 is the set/clear value |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| core_wake_req | output | 4 | Per-core special-wakeup request |
| wake_done | output | 1 | Shared wakeup-done flag |

## Verification
Every result comes from one register stage. Core requests, the done flag and read data all appear in the cycle after the clock edge that samples the access, and rsp_valid drops again one cycle later. The bench drives each access on a falling edge and holds it for one rising edge. It then compares all outputs on the next falling edge, which is the single cycle where a read response is visible. One further idle falling edge confirms that the response has gone.

// File: rtl/quad_wakeup_regs.sv
module quad_wakeup_regs #(
  parameter int          CORES    = 4,
  parameter int          IDX_W    = 32,
  parameter int          SEL_MSB  = 15,
  parameter int          DATA_W   = 64,
  parameter logic [31:0] REQ_OFS  = 32'h0000_083C,
  parameter logic [31:0] STAT_OFS = 32'h0000_082C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [IDX_W+2:0]    acc_addr,
  input  logic [3:0]          acc_size,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [CORES-1:0]    core_wake_req,
  output logic                wake_done
);

  localparam int          SEL_LSB  = SEL_MSB - CORES + 1;
  localparam logic [IDX_W-1:0] SEL_MASK =
    IDX_W'(((64'd1 << CORES) - 64'd1) << SEL_LSB);
  localparam logic [DATA_W-1:0] DONE_PAT =
    (DATA_W'(1) << (DATA_W - 2)) | (DATA_W'(1) << (DATA_W - 5));

  logic [IDX_W-1:0] idx, idx_m;
  logic             ok8, hit_req, hit_stat, wr_req, rd;
  logic             set_val;
  logic             unused_bits;

  assign idx      = acc_addr[IDX_W+2:3];
  assign idx_m    = idx & ~SEL_MASK;
  assign ok8      = (acc_size == 4'd8) && (acc_addr[2:0] == 3'b000);
  assign hit_req  = ok8 && (idx_m == IDX_W'(REQ_OFS));
  assign hit_stat = ok8 && (idx_m == IDX_W'(STAT_OFS));
  assign wr_req   = acc_valid && acc_write && hit_req;
  assign rd       = acc_valid && !acc_write;
  assign set_val  = acc_wdata[DATA_W-1];
  assign unused_bits = ^acc_wdata[DATA_W-2:0];

  for (genvar i = 0; i < CORES; i++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n)
        core_wake_req[i] <= 1'b0;
      else if (wr_req && idx[SEL_MSB-i])
        core_wake_req[i] <= set_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wake_done <= 1'b0;
    else if (wr_req)
      wake_done <= set_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd)
        rsp_rdata <= hit_stat ? (wake_done ? DONE_PAT : '0) : '1;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rsp_valid); // R9
  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rsp_valid); // R9
  AST_REQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> ($stable(core_wake_req) && $stable(wake_done))); // R7
  AST_DONE_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && ok8 && idx_m == IDX_W'(REQ_OFS))
      |=> (wake_done == $past(acc_wdata[DATA_W-1]))); // R4
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata == '1 || rsp_rdata == '0 || rsp_rdata == DONE_PAT)); // R5

endmodule

// File: tb/quad_wakeup_regs_test.sv
module quad_wakeup_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] STAT = 64'h4800_0000_0000_0000;
  localparam int NV = 16;
  // {write, index, size, set, exp_wake, exp_done, exp_rdata, req}
  localparam logic [110:0] VEC [NV] = '{
    {1'b1, 32'h0000_883C, 4'd8, 1'b1, 4'b0001, 1'b1, 64'd0, 4'd2}, // R2
    {1'b1, 32'h0000_183C, 4'd8, 1'b1, 4'b1001, 1'b1, 64'd0, 4'd2}, // R2
    {1'b0, 32'h0000_082C, 4'd8, 1'b0, 4'b1001, 1'b1, STAT,  4'd5}, // R5
    {1'b1, 32'h0000_483C, 4'd8, 1'b0, 4'b1001, 1'b0, 64'd0, 4'd4}, // R4
    {1'b0, 32'h0000_A82C, 4'd8, 1'b0, 4'b1001, 1'b0, 64'd0, 4'd5}, // R5
    {1'b1, 32'h0000_083C, 4'd8, 1'b1, 4'b1001, 1'b1, 64'd0, 4'd4}, // R4
    {1'b1, 32'h0000_883C, 4'd8, 1'b0, 4'b1000, 1'b0, 64'd0, 4'd3}, // R3
    {1'b1, 32'h0000_F83C, 4'd8, 1'b1, 4'b1111, 1'b1, 64'd0, 4'd2}, // R2
    {1'b0, 32'h0000_083C, 4'd8, 1'b0, 4'b1111, 1'b1, ONES,  4'd6}, // R6
    {1'b1, 32'h0000_1000, 4'd8, 1'b0, 4'b1111, 1'b1, 64'd0, 4'd7}, // R7
    {1'b1, 32'h0000_082C, 4'd8, 1'b0, 4'b1111, 1'b1, 64'd0, 4'd7}, // R7
    {1'b1, 32'h0000_F83C, 4'd4, 1'b0, 4'b1111, 1'b1, 64'd0, 4'd8}, // R8
    {1'b0, 32'h0000_082C, 4'd4, 1'b0, 4'b1111, 1'b1, ONES,  4'd8}, // R8
    {1'b0, 32'h0010_082C, 4'd8, 1'b0, 4'b1111, 1'b1, ONES,  4'd6}, // R6
    {1'b1, 32'h0000_283C, 4'd8, 1'b0, 4'b1011, 1'b0, 64'd0, 4'd3}, // R3
    {1'b0, 32'h0000_F82C, 4'd8, 1'b0, 4'b1011, 1'b0, 64'd0, 4'd5}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [34:0] acc_addr = '0;
  logic [3:0]  acc_size = 4'd8;
  logic [63:0] acc_wdata = '0;
  logic        rsp_valid, wake_done;
  logic [63:0] rsp_rdata;
  logic [3:0]  core_wake_req;
  int tests = 0, fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_wakeup_regs uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .core_wake_req(core_wake_req), .wake_done(wake_done));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] idx, input logic [3:0] sz,
                        input logic setv, input logic [2:0] low);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = {idx, low}; acc_size = sz;
    acc_wdata = {setv, 63'h2AAA_5555_0F0F_F0F0};
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wake", {60'd0, core_wake_req}, 64'd0);
    check("R1 done", {63'd0, wake_done}, 64'd0);
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [110:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[3:0], v);
      access(e[110], e[109:78], e[77:74], e[73], 3'd0);
      check({tag, " wake"}, {60'd0, core_wake_req}, {60'd0, e[72:69]});
      check({tag, " done"}, {63'd0, wake_done}, {63'd0, e[68]});
      check({tag, " rsp_valid R9"}, {63'd0, rsp_valid}, {63'd0, !e[110]});
      if (!e[110]) check({tag, " rdata"}, rsp_rdata, e[67:4]);
    end
    @(negedge clk);
    check("R9 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
    // misaligned write rejected (R8)
    access(1'b1, 32'h0000_F83C, 4'd8, 1'b1, 3'd4);
    check("R8 misaligned write", {59'd0, wake_done, core_wake_req}, {59'd0, 5'b01011});
    // misaligned read returns ones (R8)
    access(1'b0, 32'h0000_082C, 4'd8, 1'b0, 3'd1);
    check("R8 misaligned read", rsp_rdata, ONES);
    // back-to-back reads keep rsp_valid high (R9)
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = {32'h0000_082C, 3'd0}; acc_size = 4'd8;
    @(negedge clk);
    check("R9 first of pair", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R9 second of pair", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    check("R9 after pair", {63'd0, rsp_valid}, 64'd0);
    // reset mid-run clears state (R1)
    access(1'b1, 32'h0000_F83C, 4'd8, 1'b1, 3'd0);
    check("R2 all cores", {59'd0, wake_done, core_wake_req}, {59'd0, 5'b11111});
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset wake", {60'd0, core_wake_req}, 64'd0);
    check("R1 reset done", {63'd0, wake_done}, 64'd0);
    rst_n = 1'b1;
    access(1'b0, 32'h0000_582C, 4'd8, 1'b0, 3'd0);
    check("R5 after reset", rsp_rdata, 64'd0);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule